// File: doc/BRIEF.md
# Two-Line Edge-Triggered Interrupt Bank

This block collects up to 24 single-bit event sources and presents them to two independent hosts, each through its own active-low interrupt pin. Every source passes through a two-flop synchroniser and an edge detector. A single edge-selection array, shared by both hosts, enables rising detection, falling detection, both, or neither for each source. A detected edge is latched into a status register for each host line. Each line then gates its status with its own mask to produce its interrupt pin.

Software reaches all state through a byte-addressed register port: a write strobe, a read strobe, a 6-bit address and 8-bit data. The port is always ready, so it applies no back-pressure. A write is taken in the cycle its strobe is high. A read returns its byte on `reg_rdata` one cycle later, and `reg_rvalid` marks that cycle. A global mode bit selects how status is cleared. In one mode a read of a status byte clears the bits it returned. In the other mode host software writes ones to the bits it wants cleared. A test-set register on each line lets software raise status bits directly, so that interrupt delivery can be checked without toggling any source.

Top module: `sih_bank`

## Requirements
- R1: After reset both `irq_n` pins are high. Every status bit, every edge-selection bit and the clear-mode bit (address 0x00, bit 0) read 0. Every mask bit belonging to a real source reads 1.
- R2: An edge on source i whose direction is enabled sets status bit i on both lines no more than three clock cycles after the input changes. When both directions are enabled, either direction sets it.
- R3: A source whose two edge-selection bits are both 0 never sets status on either line, whatever its input does.
- R4: The edge-selection bytes sit at 0x30 + i/4. Source i uses bit 2*(i%4)+1 of its byte for rising edges and bit 2*(i%4) for falling edges. The one array serves both lines.
- R5: Line L (L = 0 or 1) has status bytes at 0x10*(L+1) + b, mask bytes at +4 + b and test-set bytes at +8 + b. Byte b bit k stands for source 8*b + k. Bytes and bits beyond the last source read 0.
- R6: `irq_n[L]` is low exactly while line L holds a status bit whose own mask bit on line L is 0. A mask bit of 1 only blocks the pin: status still latches. The two lines act independently.
- R7: With the clear-mode bit at 0, writing a status byte clears the bits written as 1 and leaves the rest. Reading a status byte leaves status unchanged.
- R8: With the clear-mode bit at 1, reading a status byte clears exactly the bits returned by that read. Writes to status bytes have no effect in this mode.
- R9: An edge whose status update falls in the same cycle as a clearing read or write of that bit survives. It shows in the following read.
- R10: Writing ones to a line's test-set byte sets those status bits on that line only. Test-set bytes read 0.
- R11: Each `reg_rd` pulse yields exactly one `reg_rvalid` pulse in the next cycle, carrying the addressed byte as it stood when the read was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | N_SRC | Asynchronous event source levels |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| irq_n | output | 2 | Active-low interrupt, one per host line |

## Verification
A status bit latched wrongly shows up at once on the interrupt pin of any line that leaves it unmasked. It also shows up at the next read of its byte, one cycle after the read strobe. A wrongly packed edge-selection byte appears as a missing or extra status bit about three cycles after the source toggles. A clear path in the wrong mode appears as a stale or vanished bit on the very next read of the same byte. The coincident-edge case is driven so that the set and the clear land on the same clock edge. A design in which the clear wins loses the bit, and the follow-up read exposes that.

// File: rtl/sih_pkg.sv
package sih_pkg;
  // register port geometry
  localparam int unsigned REG_AW  = 6;
  localparam int unsigned N_LINES = 2;
  localparam int unsigned MAX_SRC = 24;

  // address regions, selected by addr[5:4]
  localparam logic [1:0] RGN_CTRL = 2'd0;
  localparam logic [1:0] RGN_EDGE = 2'd3;
  localparam logic [REG_AW-1:0] ADDR_CTRL = 6'h00;

  // register kind inside a line window, selected by addr[3:2]
  typedef enum logic [1:0] {
    K_STAT = 2'd0,
    K_MASK = 2'd1,
    K_TSET = 2'd2,
    K_NONE = 2'd3
  } line_reg_e;
endpackage

// File: rtl/sih_edge_detect.sv
module sih_edge_detect #(
  parameter int unsigned N_SRC = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] rise_en_i,
  input  logic [N_SRC-1:0] fall_en_i,
  output logic [N_SRC-1:0] evt_o
);
  logic [N_SRC-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= src_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  // one-cycle event per qualifying transition of the synchronised level
  assign evt_o = (sync_q & ~prev_q & rise_en_i) | (~sync_q & prev_q & fall_en_i);
endmodule

// File: rtl/sih_line.sv
module sih_line #(
  parameter int unsigned N_SRC = 24,
  localparam int unsigned NB   = (N_SRC + 7) / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             cor_i,
  input  logic [NB-1:0]    stat_wr_sel,
  input  logic [NB-1:0]    stat_rd_sel,
  input  logic [NB-1:0]    mask_wr_sel,
  input  logic [NB-1:0]    tset_wr_sel,
  input  logic [7:0]       wdata,
  output logic [N_SRC-1:0] status_o,
  output logic [N_SRC-1:0] mask_o,
  output logic             irq_n_o
);
  logic [N_SRC-1:0] status_q, mask_q;
  logic [N_SRC-1:0] clr_vec, tset_vec, mask_we, set_vec;

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    localparam int unsigned BY = i / 8;
    localparam int unsigned BI = i % 8;
    // clear source depends on mode: read strobe or write-one
    assign clr_vec[i]  = cor_i ? stat_rd_sel[BY] : (stat_wr_sel[BY] & wdata[BI]);
    assign tset_vec[i] = tset_wr_sel[BY] & wdata[BI];
    assign mask_we[i]  = mask_wr_sel[BY];
  end

  assign set_vec = evt_i | tset_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      // set has priority so a coincident event is never lost
      status_q <= (status_q & ~clr_vec) | set_vec;
      for (int i = 0; i < N_SRC; i++)
        if (mask_we[i]) mask_q[i] <= wdata[i % 8];
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_n_o  = ~|(status_q & ~mask_q);

  AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i))); // R2

  AST_NO_SILENT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0) |=> (($past(status_q) & ~status_q) == '0)); // R7

  AST_TSET_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    (tset_vec != '0) |=> ((status_q & $past(tset_vec)) == $past(tset_vec))); // R10
endmodule

// File: rtl/sih_bank.sv
module sih_bank
  import sih_pkg::*;
#(
  parameter int unsigned N_SRC = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SRC-1:0]     src_i,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  output logic                 reg_rvalid,
  output logic [N_LINES-1:0]   irq_n
);
  localparam int unsigned NB = (N_SRC + 7) / 8;  // status/mask bytes per line
  localparam int unsigned EB = (N_SRC + 3) / 4;  // edge-selection bytes

  logic             cor_q;
  logic [EB*8-1:0]  edge_q;
  logic [N_SRC-1:0] rise_en, fall_en, evt;
  logic [N_SRC-1:0] stat_w [N_LINES];
  logic [N_SRC-1:0] mask_w [N_LINES];
  logic [NB*8-1:0]  stat_pad [N_LINES];
  logic [NB*8-1:0]  mask_pad [N_LINES];
  logic [1:0]       region;
  line_reg_e        kind;
  logic [7:0]       rd_d;
  logic [7:0]       rdata_q;
  logic             rvalid_q;

  assign region = reg_addr[5:4];
  assign kind   = line_reg_e'(reg_addr[3:2]);

  // shared control and edge-selection storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cor_q  <= 1'b0;
      edge_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_CTRL) cor_q <= reg_wdata[0];
      for (int k = 0; k < EB; k++)
        if (reg_addr == REG_AW'(48 + k)) edge_q[k*8 +: 8] <= reg_wdata;
    end
  end

  // two bits per source, four sources per byte, rising bit above falling
  for (genvar i = 0; i < N_SRC; i++) begin : g_edge_map
    assign rise_en[i] = edge_q[(i / 4) * 8 + (i % 4) * 2 + 1];
    assign fall_en[i] = edge_q[(i / 4) * 8 + (i % 4) * 2];
  end

  sih_edge_detect #(.N_SRC(N_SRC)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .rise_en_i (rise_en),
    .fall_en_i (fall_en),
    .evt_o     (evt)
  );

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    logic [NB-1:0] s_wr, s_rd, m_wr, t_wr;
    for (genvar b = 0; b < NB; b++) begin : g_byte
      logic hit;
      assign hit     = (region == 2'(l + 1)) && (reg_addr[1:0] == 2'(b));
      assign s_wr[b] = reg_wr & hit & (kind == K_STAT);
      assign s_rd[b] = reg_rd & hit & (kind == K_STAT);
      assign m_wr[b] = reg_wr & hit & (kind == K_MASK);
      assign t_wr[b] = reg_wr & hit & (kind == K_TSET);
    end

    sih_line #(.N_SRC(N_SRC)) u_line (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt),
      .cor_i       (cor_q),
      .stat_wr_sel (s_wr),
      .stat_rd_sel (s_rd),
      .mask_wr_sel (m_wr),
      .tset_wr_sel (t_wr),
      .wdata       (reg_wdata),
      .status_o    (stat_w[l]),
      .mask_o      (mask_w[l]),
      .irq_n_o     (irq_n[l])
    );

    assign stat_pad[l] = (NB*8)'(stat_w[l]);
    assign mask_pad[l] = (NB*8)'(mask_w[l]);
  end

  // read mux: unmapped locations and test-set bytes return zero
  always_comb begin
    rd_d = '0;
    unique case (region)
      RGN_CTRL: if (reg_addr == ADDR_CTRL) rd_d = {7'b0, cor_q};
      RGN_EDGE: begin
        if (!reg_addr[3])
          for (int k = 0; k < EB; k++)
            if (reg_addr[2:0] == 3'(k)) rd_d = edge_q[k*8 +: 8];
      end
      default: begin
        for (int b = 0; b < NB; b++)
          if (reg_addr[1:0] == 2'(b)) begin
            if (kind == K_STAT)      rd_d = stat_pad[reg_addr[5]][b*8 +: 8];
            else if (kind == K_MASK) rd_d = mask_pad[reg_addr[5]][b*8 +: 8];
          end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= reg_rd;
      if (reg_rd) rdata_q <= rd_d;
    end
  end

  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;

  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid); // R11

  AST_RVALID_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid); // R11
endmodule

// File: tb/sih_bank_bench.sv
module sih_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] src = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        reg_rvalid;
  logic [1:0]  irq_n;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  bit         done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sih_bank #(.N_SRC(24)) u_sih_bank (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .irq_n(irq_n)
  );

  // driver side: issue one read and queue its expected byte
  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic chk_irq(input logic [1:0] e, input string tag);
    checks++;
    if (irq_n !== e) begin
      fails++;
      $display("FAIL %s irq_n actual=%b expected=%b", tag, irq_n, e);
    end
  endtask

  // monitor side: compare each returned byte against the queue (R11 timing)
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected rvalid actual=%02h expected=none", reg_rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          fails++;
          $display("FAIL %s rdata actual=%02h expected=%02h", t, reg_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_irq(2'b11, "R1");
    rd(6'h00, 8'h00, "R1");
    rd(6'h10, 8'h00, "R1");
    rd(6'h12, 8'h00, "R1");
    rd(6'h14, 8'hFF, "R1");
    rd(6'h26, 8'hFF, "R1");
    rd(6'h30, 8'h00, "R1");
    rd(6'h35, 8'h00, "R1");

    // R3 edges ignored when both selection bits are 0
    src[0] = 1'b1; settle();
    src[0] = 1'b0; settle();
    rd(6'h10, 8'h00, "R3");
    rd(6'h20, 8'h00, "R3");
    chk_irq(2'b11, "R3");

    // R2/R4/R6 rising edge on source 0, line 0 unmasked only
    wr(6'h30, 8'h02);
    wr(6'h14, 8'hFE);
    src[0] = 1'b1; settle();
    chk_irq(2'b10, "R6");
    rd(6'h20, 8'h01, "R2");
    rd(6'h10, 8'h01, "R4");
    src[0] = 1'b0; settle();

    // R7 write-one-to-clear mode
    rd(6'h10, 8'h01, "R7");
    wr(6'h10, 8'h01);
    rd(6'h10, 8'h00, "R7");
    chk_irq(2'b11, "R7");

    // R4 falling-only on source 9 (byte 2, bit 2)
    wr(6'h32, 8'h04);
    src[9] = 1'b1; settle();
    rd(6'h11, 8'h00, "R4");
    src[9] = 1'b0; settle();
    rd(6'h11, 8'h02, "R2");
    rd(6'h21, 8'h02, "R4");

    // R2 both edges on source 23 (byte 5, bits 7:6)
    wr(6'h35, 8'hC0);
    src[23] = 1'b1; settle();
    rd(6'h22, 8'h80, "R2");
    wr(6'h22, 8'h80);
    rd(6'h22, 8'h00, "R7");
    src[23] = 1'b0; settle();
    rd(6'h22, 8'h80, "R2");

    // R6 lines independent
    wr(6'h26, 8'h7F);
    chk_irq(2'b01, "R6");
    wr(6'h26, 8'hFF);
    chk_irq(2'b11, "R6");

    // R10 test-set
    wr(6'h20, 8'hFF);
    rd(6'h20, 8'h00, "R7");
    wr(6'h28, 8'h40);
    rd(6'h20, 8'h40, "R10");
    rd(6'h10, 8'h00, "R10");
    rd(6'h28, 8'h00, "R10");

    // R5 layout and out-of-range bytes
    wr(6'h1B, 8'hFF);
    rd(6'h13, 8'h00, "R5");
    rd(6'h17, 8'h00, "R5");
    wr(6'h1A, 8'h01);
    rd(6'h12, 8'h81, "R5");
    wr(6'h12, 8'h81);

    // R8 clear-on-read mode
    wr(6'h00, 8'h01);
    rd(6'h00, 8'h01, "R8");
    rd(6'h20, 8'h40, "R8");
    rd(6'h20, 8'h00, "R8");
    wr(6'h28, 8'h40);
    wr(6'h20, 8'hFF);
    rd(6'h20, 8'h40, "R8");
    rd(6'h20, 8'h00, "R8");

    // R9 edge lands on the same clock edge as the clearing read
    src[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(6'h10, 8'h00, "R9");
    chk_irq(2'b10, "R9");
    rd(6'h10, 8'h01, "R9");
    chk_irq(2'b11, "R9");
    rd(6'h10, 8'h00, "R9");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R11 missing rvalid actual=%0d pending expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule